// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This block copies a block of bytes from a synchronous memory to one peripheral so that the processor does not move the data itself. Software first writes a few configuration words: the first memory address, how many bytes to move, the peripheral's bus address and a limit on how long to wait for the peripheral. It then writes a start command. The engine reads one byte at a time over the memory port it shares with the processor. For each byte it takes exactly one bus cycle, with priority over the processor, and then leaves the bus free. It hands each byte to the peripheral with a ready/acknowledge exchange that is watched by a wait counter.

When the last byte is acknowledged, the engine sets a completion flag and raises its interrupt. It does the same when the peripheral reports an error or fails to answer in time, and in those cases it also sets a flag that gives the cause. Software clears the flags by writing ones to them.

Register selects on `reg_sel`: 0 source address, 1 byte count, 2 peripheral address, 3 wait limit, 4 control (data bit 0 = start), 5 status clear (write 1 to clear). The status word `stat` is {error bit 3, timeout bit 2, busy bit 1, done bit 0}.

Top module: `dma_steal_engine`

## Requirements
- R1: After reset, `stat` is 0, `irq` is low, `dev_rdy` is low and the engine makes no memory access.
- R2: A start with count N>0 delivers the bytes stored at source, source+1, ..., source+N-1 to the peripheral in that order, each with `dev_addr` equal to the programmed peripheral address. `stat` bit 1 is high while the transfer runs, and the transfer ends with `stat` = 4'b0001.
- R3: In a cycle where both the engine and the processor request memory, the engine wins and `cpu_mem_gnt` is low. A transfer of N bytes takes exactly N such cycles.
- R4: The engine never holds the memory bus in two consecutive cycles.
- R5: `dev_rdy` stays high until the peripheral answers, and `dev_data` does not change while `dev_rdy` is high.
- R6: If neither `dev_ack` nor `dev_err` arrives while `dev_rdy` has been high for the programmed limit of cycles, `dev_rdy` falls after exactly that many cycles. The transfer then stops with no further bus access, and `stat` becomes 4'b0101.
- R7: `dev_err` sampled while `dev_rdy` is high ends the transfer without delivering that byte, and `stat` becomes 4'b1001.
- R8: `irq` equals the done bit. Writing select 5 clears exactly the flag bits set in the data word (bit 0 done, bit 2 timeout, bit 3 error), and clearing done drops `irq`.
- R9: While busy, a start command or a write to any configuration register has no effect on the transfer in progress.
- R10: A start with count 0 sets done on the clock edge that accepts the write, with no memory access and no `dev_rdy`.
- R11: An accepted start clears the done, timeout and error flags left by the previous transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| stat | output | 4 | Status {error, timeout, busy, done} |
| irq | output | 1 | Interrupt, high while done is set |
| cpu_mem_req | input | 1 | Processor memory request |
| cpu_mem_addr | input | 16 | Processor memory address |
| cpu_mem_gnt | output | 1 | Processor owns the memory this cycle |
| mem_en | output | 1 | Memory read enable |
| mem_addr | output | 16 | Memory address |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the access |
| dev_addr | output | 8 | Peripheral address |
| dev_data | output | 8 | Byte offered to the peripheral |
| dev_rdy | output | 1 | Byte ready |
| dev_ack | input | 1 | Peripheral accepts the byte |
| dev_err | input | 1 | Peripheral reports an error |

## Verification
A wrong byte index or a wrong source address shows up at the first handshake after the fault, as a byte that does not match what the bench expects from memory. A stuck or mis-sequenced state shows within one or two cycles, either as a bus access that follows another at once or as a handshake that never starts, which the bench reports as a count mismatch. A wait counter that is off by one changes the measured length of the `dev_rdy` pulse in the timeout case. Flag logic that sets or clears the wrong bit shows in the next `stat` sample after the write or after the end of the transfer.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DATA = 2'd2,
        ST_HAND = 2'd3
    } xfer_st_e;

    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_CNT  = 3'd1;
    localparam logic [2:0] SEL_DEV  = 3'd2;
    localparam logic [2:0] SEL_LIM  = 3'd3;
    localparam logic [2:0] SEL_CTRL = 3'd4;
    localparam logic [2:0] SEL_STAT = 3'd5;
endpackage

// File: rtl/dma_bus_arb.sv
module dma_bus_arb #(
    parameter int AW = 16
) (
    input  logic          dma_req,
    input  logic [AW-1:0] dma_addr,
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    output logic          dma_gnt,
    output logic          cpu_gnt,
    output logic          mem_en,
    output logic [AW-1:0] mem_addr
);
    // the engine always wins; the processor gets every other cycle
    always_comb begin
        dma_gnt  = dma_req;
        cpu_gnt  = cpu_req && !dma_req;
        mem_en   = dma_req || cpu_req;
        mem_addr = dma_req ? dma_addr : cpu_addr;
    end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int RW = 32,
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 8,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [2:0]    sel,
    input  logic [RW-1:0] wdata,
    input  logic          busy,
    input  logic          fin,
    input  logic          fin_tmo,
    input  logic          fin_err,
    output logic [AW-1:0] src,
    output logic [CW-1:0] cnt,
    output logic [DW-1:0] dev,
    output logic [TW-1:0] lim,
    output logic          start,
    output logic [3:0]    stat,
    output logic          irq
);
    typedef struct packed {
        logic [AW-1:0] src;
        logic [CW-1:0] cnt;
        logic [DW-1:0] dev;
        logic [TW-1:0] lim;
        logic          done;
        logic          tmo;
        logic          err;
    } regs_t;

    regs_t q, d;
    logic  unused_wbits;

    assign unused_wbits = ^wdata;
    assign start = wr && (sel == SEL_CTRL) && wdata[0] && !busy;

    always_comb begin
        d = q;
        if (wr && !busy) begin
            case (sel)
                SEL_SRC: d.src = wdata[AW-1:0];
                SEL_CNT: d.cnt = wdata[CW-1:0];
                SEL_DEV: d.dev = wdata[DW-1:0];
                SEL_LIM: d.lim = wdata[TW-1:0];
                default: ;
            endcase
        end
        if (start) begin
            d.done = 1'b0;
            d.tmo  = 1'b0;
            d.err  = 1'b0;
        end
        if (wr && sel == SEL_STAT) begin
            if (wdata[0]) d.done = 1'b0;
            if (wdata[2]) d.tmo  = 1'b0;
            if (wdata[3]) d.err  = 1'b0;
        end
        if (fin) begin
            d.done = 1'b1;
            if (fin_tmo) d.tmo = 1'b1;
            if (fin_err) d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign src  = q.src;
    assign cnt  = q.cnt;
    assign dev  = q.dev;
    assign lim  = q.lim;
    assign stat = {q.err, q.tmo, busy, q.done};
    assign irq  = q.done;

    p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr && sel == SEL_CNT) |=> $stable(cnt));
    p_done_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> irq);
    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_STAT && wdata[0] && !fin) |=> !irq);
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int TW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src,
    input  logic [CW-1:0] cnt,
    input  logic [TW-1:0] lim,
    input  logic          mem_gnt,
    input  logic [BW-1:0] mem_rdata,
    input  logic          dev_ack,
    input  logic          dev_err,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          dev_rdy,
    output logic [BW-1:0] dev_data,
    output logic          busy,
    output logic          fin,
    output logic          fin_tmo,
    output logic          fin_err
);
    typedef struct packed {
        xfer_st_e      st;
        logic [CW-1:0] idx;
        logic [TW-1:0] tmr;
        logic [BW-1:0] data;
    } fsm_t;

    fsm_t q, d;
    logic tmr_last;
    logic idx_last;

    assign tmr_last = ({1'b0, q.tmr} + (TW+1)'(1)) >= {1'b0, lim};
    assign idx_last = (q.idx + CW'(1)) == cnt;

    always_comb begin
        d       = q;
        fin     = 1'b0;
        fin_tmo = 1'b0;
        fin_err = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (cnt == '0) begin
                        fin = 1'b1;
                    end else begin
                        d.st  = ST_REQ;
                        d.idx = '0;
                    end
                end
            end
            ST_REQ: begin
                if (mem_gnt) d.st = ST_DATA;
            end
            ST_DATA: begin
                d.data = mem_rdata;
                d.tmr  = '0;
                d.st   = ST_HAND;
            end
            ST_HAND: begin
                if (dev_err) begin
                    fin     = 1'b1;
                    fin_err = 1'b1;
                    d.st    = ST_IDLE;
                end else if (dev_ack) begin
                    if (idx_last) begin
                        fin  = 1'b1;
                        d.st = ST_IDLE;
                    end else begin
                        d.idx = q.idx + CW'(1);
                        d.st  = ST_REQ;
                    end
                end else if (tmr_last) begin
                    fin     = 1'b1;
                    fin_tmo = 1'b1;
                    d.st    = ST_IDLE;
                end else begin
                    d.tmr = q.tmr + TW'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign mem_req  = (q.st == ST_REQ);
    assign mem_addr = src + AW'(q.idx);
    assign dev_rdy  = (q.st == ST_HAND);
    assign dev_data = q.data;
    assign busy     = (q.st != ST_IDLE);

    p_bus_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rdy && $past(dev_rdy)) |-> $stable(dev_data));
    p_wait_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rdy && lim != '0) |-> (q.tmr < lim));
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!dev_rdy && !mem_req));
endmodule

// File: rtl/dma_steal_engine.sv
module dma_steal_engine #(
    parameter int RW = 32,
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 8,
    parameter int TW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_sel,
    input  logic [RW-1:0] reg_wdata,
    output logic [3:0]    stat,
    output logic          irq,
    input  logic          cpu_mem_req,
    input  logic [AW-1:0] cpu_mem_addr,
    output logic          cpu_mem_gnt,
    output logic          mem_en,
    output logic [AW-1:0] mem_addr,
    input  logic [BW-1:0] mem_rdata,
    output logic [DW-1:0] dev_addr,
    output logic [BW-1:0] dev_data,
    output logic          dev_rdy,
    input  logic          dev_ack,
    input  logic          dev_err
);
    logic [AW-1:0] cfg_src;
    logic [CW-1:0] cfg_cnt;
    logic [TW-1:0] cfg_lim;
    logic          start, busy, fin, fin_tmo, fin_err;
    logic          dma_req, dma_gnt;
    logic [AW-1:0] dma_addr;

    dma_regs #(.RW(RW), .AW(AW), .CW(CW), .DW(DW), .TW(TW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
        .busy(busy), .fin(fin), .fin_tmo(fin_tmo), .fin_err(fin_err),
        .src(cfg_src), .cnt(cfg_cnt), .dev(dev_addr), .lim(cfg_lim),
        .start(start), .stat(stat), .irq(irq)
    );

    dma_xfer_fsm #(.AW(AW), .CW(CW), .TW(TW), .BW(BW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .src(cfg_src), .cnt(cfg_cnt),
        .lim(cfg_lim), .mem_gnt(dma_gnt), .mem_rdata(mem_rdata),
        .dev_ack(dev_ack), .dev_err(dev_err), .mem_req(dma_req),
        .mem_addr(dma_addr), .dev_rdy(dev_rdy), .dev_data(dev_data),
        .busy(busy), .fin(fin), .fin_tmo(fin_tmo), .fin_err(fin_err)
    );

    dma_bus_arb #(.AW(AW)) u_arb (
        .dma_req(dma_req), .dma_addr(dma_addr), .cpu_req(cpu_mem_req),
        .cpu_addr(cpu_mem_addr), .dma_gnt(dma_gnt), .cpu_gnt(cpu_mem_gnt),
        .mem_en(mem_en), .mem_addr(mem_addr)
    );

    p_cpu_yield_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mem_req && !cpu_mem_gnt) |=> cpu_mem_gnt || !cpu_mem_req);
endmodule

// File: tb/test_dma_steal_engine.sv
`timescale 1ns/1ps
module test_dma_steal_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  stat;
    logic        irq;
    logic        cpu_mem_req = 1'b0;
    logic [15:0] cpu_mem_addr = 16'h0100;
    logic        cpu_mem_gnt;
    logic        mem_en;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  dev_addr;
    logic [7:0]  dev_data;
    logic        dev_rdy;
    logic        dev_ack = 1'b0;
    logic        dev_err = 1'b0;

    int checks = 0;
    int errors = 0;

    // device behaviour knobs
    int ack_delay = 0;
    int ack_bytes = 1000;
    int err_at    = -1;
    // monitor bookkeeping
    int byte_idx  = 0;
    int delivered = 0;
    int run_len   = 0;
    int last_len  = 0;
    int dma_cyc   = 0;
    int rdy_seen  = 0;
    logic       prev_dma = 1'b0;
    logic [7:0] held = '0;
    logic [15:0] exp_q[$];

    always #2.5 clk = ~clk;

    dma_steal_engine i_dma_steal_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .stat(stat), .irq(irq),
        .cpu_mem_req(cpu_mem_req), .cpu_mem_addr(cpu_mem_addr),
        .cpu_mem_gnt(cpu_mem_gnt), .mem_en(mem_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .dev_addr(dev_addr), .dev_data(dev_data),
        .dev_rdy(dev_rdy), .dev_ack(dev_ack), .dev_err(dev_err)
    );

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] * 8'd7 + 8'd3;
    endfunction

    always @(posedge clk) begin
        if (mem_en) mem_rdata <= memf(mem_addr);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor and peripheral model
    always @(negedge clk) begin
        logic dma_now;
        dev_ack = 1'b0;
        dev_err = 1'b0;
        if (rst_n) begin
            dma_now = mem_en && !cpu_mem_gnt;
            if (dma_now) begin
                dma_cyc++;
                if (prev_dma) check(1'b0, "R4 back-to-back bus use", 1, 0);
            end
            if (cpu_mem_req && dma_now && cpu_mem_gnt)
                check(1'b0, "R3 processor granted over engine", 1, 0);
            prev_dma = dma_now;
            if (dev_rdy) begin
                rdy_seen++;
                if (run_len > 0 && dev_data != held)
                    check(1'b0, "R5 data moved during ready", int'(dev_data), int'(held));
                held = dev_data;
                run_len++;
                if (byte_idx == err_at) begin
                    dev_err = 1'b1;
                    byte_idx++;
                end else if (byte_idx < ack_bytes && run_len == ack_delay + 1) begin
                    dev_ack = 1'b1;
                    byte_idx++;
                    delivered++;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2 unexpected byte", int'(dev_data), -1);
                    end else begin
                        logic [15:0] e;
                        e = exp_q.pop_front();
                        check({dev_addr, dev_data} == e, "R2 byte/address",
                              int'({dev_addr, dev_data}), int'(e));
                    end
                end
            end else if (run_len > 0) begin
                last_len = run_len;
                run_len = 0;
            end
        end
    end

    task automatic wr_reg(input logic [2:0] s, input logic [31:0] v);
        reg_sel   = s;
        reg_wdata = v;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic clear_mon();
        byte_idx = 0; delivered = 0; dma_cyc = 0; rdy_seen = 0; last_len = 0;
        exp_q.delete();
    endtask

    // driver: programs the engine and queues the bytes expected at the device
    task automatic launch(input logic [15:0] src, input int n, input logic [7:0] dv,
                          input logic [15:0] lim, input int n_exp);
        clear_mon();
        for (int i = 0; i < n_exp; i++)
            exp_q.push_back({dv, memf(src + 16'(i))});
        wr_reg(3'd0, 32'(src));
        wr_reg(3'd1, 32'(n));
        wr_reg(3'd2, 32'(dv));
        wr_reg(3'd3, 32'(lim));
        wr_reg(3'd4, 32'd1);
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(stat == 4'b0000, "R1 stat", int'(stat), 0);
        check(!irq && !dev_rdy && !mem_en, "R1 quiet outputs",
              int'({irq, dev_rdy, mem_en}), 0);

        // R2 basic transfer
        ack_delay = 0;
        launch(16'd16, 5, 8'h3A, 16'd50, 5);
        check(stat[1] == 1'b1, "R2 busy during transfer", int'(stat), 2);
        wait_irq();
        check(stat == 4'b0001, "R2 final status", int'(stat), 1);
        check(delivered == 5 && exp_q.size() == 0, "R2 bytes delivered", delivered, 5);
        check(dma_cyc == 5, "R3 one bus cycle per byte", dma_cyc, 5);

        // R3/R4/R5 with processor contending and slow peripheral
        wr_reg(3'd5, 32'h1);
        cpu_mem_req = 1'b1;
        ack_delay = 3;
        launch(16'd200, 4, 8'h51, 16'd50, 4);
        wait_irq();
        cpu_mem_req = 1'b0;
        check(dma_cyc == 4, "R3 cycles taken from processor", dma_cyc, 4);
        check(delivered == 4, "R5 slow handshake bytes", delivered, 4);
        check(stat == 4'b0001, "R2 status after contended run", int'(stat), 1);

        // R8 clear done
        check(irq == 1'b1, "R8 irq follows done", int'(irq), 1);
        wr_reg(3'd5, 32'h1);
        check(irq == 1'b0 && stat == 4'b0000, "R8 clear done", int'(stat), 0);

        // R6 timeout on second byte
        ack_delay = 0;
        ack_bytes = 1;
        launch(16'd40, 3, 8'h22, 16'd6, 1);
        wait_irq();
        repeat (3) @(negedge clk);
        check(stat == 4'b0101, "R6 timeout status", int'(stat), 5);
        check(last_len == 6, "R6 ready length", last_len, 6);
        check(delivered == 1 && dma_cyc == 2, "R6 no access after abort", dma_cyc, 2);
        ack_bytes = 1000;

        // R8 partial clear: done only
        wr_reg(3'd5, 32'h1);
        check(stat == 4'b0100 && !irq, "R8 clear keeps timeout", int'(stat), 4);

        // R11 start clears flags, R9 writes while busy ignored
        ack_delay = 4;
        launch(16'd80, 3, 8'h77, 16'd50, 3);
        check(stat == 4'b0010, "R11 flags cleared on start", int'(stat), 2);
        repeat (3) @(negedge clk);
        wr_reg(3'd1, 32'd9);
        wr_reg(3'd2, 32'h99);
        wr_reg(3'd4, 32'd1);
        wait_irq();
        repeat (10) @(negedge clk);
        check(delivered == 3 && exp_q.size() == 0, "R9 busy writes ignored", delivered, 3);
        check(stat == 4'b0001, "R11 clean completion", int'(stat), 1);

        // R7 error on third byte
        ack_delay = 1;
        err_at = 2;
        launch(16'd300, 4, 8'h0C, 16'd50, 2);
        wait_irq();
        repeat (3) @(negedge clk);
        check(stat == 4'b1001, "R7 error status", int'(stat), 9);
        check(delivered == 2, "R7 bytes before error", delivered, 2);
        err_at = -1;

        // R10 zero count
        clear_mon();
        wr_reg(3'd1, 32'd0);
        wr_reg(3'd4, 32'd1);
        check(irq == 1'b1 && stat == 4'b0001, "R10 immediate done", int'(stat), 1);
        repeat (5) @(negedge clk);
        check(dma_cyc == 0 && rdy_seen == 0, "R10 no activity", dma_cyc + rdy_seen, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule